// File: doc/BRIEF.md
# Link Port Boot Receiver

This block fills a processor's internal memory with its boot image straight after reset, taking the image over a 4-bit link port. On the first system clock after reset is released it decodes three boot-strap pins. Only one of the eight combinations selects link-port boot; any other combination leaves the block idle.

Once loading is enabled, an external sender drives a strobe and a 4-bit data bus. Each falling strobe edge captures one nibble. Twelve nibbles, most significant first, form one 48-bit instruction word; the receive path always works at this width. Each finished word crosses into the system clock domain through a toggle handshake with a holding register. The word is then written to consecutive memory addresses, starting at a parameterised base address.

After a fixed number of words (256 by default), the block raises a completion flag and keeps it high until the next reset. It ignores any strobe activity after that point.

The control state machine has four states:
- **ST_STRAP**: decodes the straps, then moves to ST_LOAD when they match or to ST_OFF when they do not.
- **ST_OFF**: idle until reset.
- **ST_LOAD**: accepts words. It moves to ST_DONE when it writes the last word.
- **ST_DONE**: terminal until reset.

Top module: `lpboot_rx`

## Requirements
- R1: Loading is enabled only when, on the first clock after reset release, `strap_ext`=0, `strap_link`=1 and `strap_sel`=1. With any other combination the block makes no memory write, and `boot_active` and `boot_done` stay 0.
- R2: A nibble is captured from `lnk_dat` on each falling edge of `lnk_clk`. The first nibble of a word lands in bits 47:44 and the twelfth in bits 3:0.
- R3: Each completed word produces exactly one `mem_we` pulse, one clock cycle wide, with `mem_wdata` equal to the assembled word.
- R4: The k-th word (counting from 0) is written to address `BOOT_BASE`+k.
- R5: After exactly `BOOT_WORDS` (256) writes, `boot_done` rises in the same cycle as the final write pulse and stays high until reset.
- R6: Once `boot_done` is high, further strobe edges cause no memory write.
- R7: Nibbles of an incomplete word that are pending when reset is asserted are discarded. The first word after reset starts from a nibble count of zero.
- R8: No word is lost with a strobe period as short as one system clock period.
- R9: `boot_active` is 1 exactly while the block is accepting words (state ST_LOAD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, shared by both domains |
| strap_ext | input | 1 | Boot strap: must be 0 for link boot |
| strap_link | input | 1 | Boot strap: must be 1 for link boot |
| strap_sel | input | 1 | Boot strap: must be 1 for link boot |
| lnk_clk | input | 1 | External strobe; data is captured on its falling edge |
| lnk_dat | input | 4 | Link data nibble |
| mem_we | output | 1 | One-cycle memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 48 | Memory write data |
| boot_active | output | 1 | High while words are accepted |
| boot_done | output | 1 | High after the last word has been written, until reset |

## Verification
A memory write appears two to four system clocks after the twelfth falling strobe edge of its word. That range covers two synchroniser stages, the edge detector and the registered write outputs. The bench therefore does not tie a write to a fixed cycle: it checks every write pulse, at the falling clock edge, against the next expected word and address, in order. The total write count is checked eight clocks after the last strobe, which is past the latest possible write. Strap decoding is checked one clock after reset release plus margin, and `boot_done` is checked against the write index at every pulse.

// File: rtl/lpboot_pkg.sv
package lpboot_pkg;
    localparam int WORD_W = 48;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_OFF   = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DONE  = 2'd3
    } boot_state_t;
endpackage

// File: rtl/lpboot_nibasm.sv
module lpboot_nibasm
    import lpboot_pkg::*;
(
    input  logic              lnk_clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [NIB_W-1:0]  lnk_dat,
    output logic [WORD_W-1:0] word_hold,
    output logic              word_tgl
);
    localparam int NIB_N = WORD_W / NIB_W;
    localparam int CNT_W = $clog2(NIB_N);
    localparam int SH_W  = WORD_W - NIB_W;

    logic [CNT_W-1:0] nib_cnt;
    logic [SH_W-1:0]  shift_q;

    // Strobe domain: capture on the falling edge; reset drops any partial word
    always_ff @(negedge lnk_clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_cnt   <= '0;
            shift_q   <= '0;
            word_hold <= '0;
            word_tgl  <= 1'b0;
        end else if (cap_en) begin
            if (nib_cnt == CNT_W'(NIB_N - 1)) begin
                word_hold <= {shift_q, lnk_dat};
                word_tgl  <= ~word_tgl;
                nib_cnt   <= '0;
            end else begin
                shift_q <= {shift_q[SH_W-NIB_W-1:0], lnk_dat};
                nib_cnt <= nib_cnt + 1'b1;
            end
        end
    end

    // R2
    nib_cnt_range_chk: assert property (@(negedge lnk_clk) disable iff (!rst_n)
        nib_cnt < CNT_W'(NIB_N));
endmodule

// File: rtl/lpboot_tglsync.sv
module lpboot_tglsync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic s_meta, s_sync, s_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_last <= 1'b0;
        end else begin
            s_meta <= tgl_in;
            s_sync <= s_meta;
            s_last <= s_sync;
        end
    end

    assign pulse = s_sync ^ s_last;
endmodule

// File: rtl/lpboot_ctrl.sv
module lpboot_ctrl
    import lpboot_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BOOT_WORDS = 256,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 17'h04000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ext,
    input  logic              strap_link,
    input  logic              strap_sel,
    input  logic              word_pulse,
    input  logic [WORD_W-1:0] word_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              boot_active,
    output logic              boot_done
);
    localparam int IDX_W = $clog2(BOOT_WORDS);

    boot_state_t state, state_nxt;
    logic [IDX_W-1:0] idx_q;
    logic strap_ok, last_word;

    assign strap_ok  = !strap_ext && strap_link && strap_sel;
    assign last_word = (idx_q == IDX_W'(BOOT_WORDS - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STRAP: state_nxt = strap_ok ? ST_LOAD : ST_OFF;
            ST_OFF:   state_nxt = ST_OFF;
            ST_LOAD:  if (word_pulse && last_word) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_DONE;
            default:  state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STRAP;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= BOOT_BASE;
            mem_wdata <= '0;
            idx_q     <= '0;
            boot_done <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (state == ST_LOAD && word_pulse) begin
                mem_we    <= 1'b1;
                mem_wdata <= word_in;
                mem_addr  <= BOOT_BASE + ADDR_W'(idx_q);
                idx_q     <= idx_q + 1'b1;
                if (last_word) boot_done <= 1'b1;
            end
        end
    end

    assign boot_active = (state == ST_LOAD);

    // R3
    we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
    // R6
    no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !mem_we) |=> !mem_we);
    // R1
    off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!mem_we && !boot_done));
    // R9
    active_excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(boot_active && boot_done));
endmodule

// File: rtl/lpboot_rx.sv
module lpboot_rx
    import lpboot_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BOOT_WORDS = 256,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 17'h04000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ext,
    input  logic              strap_link,
    input  logic              strap_sel,
    input  logic              lnk_clk,
    input  logic [3:0]        lnk_dat,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [47:0]       mem_wdata,
    output logic              boot_active,
    output logic              boot_done
);
    logic [WORD_W-1:0] word_hold;
    logic              word_tgl, word_pulse;

    lpboot_nibasm u_nibasm (
        .lnk_clk   (lnk_clk),
        .rst_n     (rst_n),
        .cap_en    (boot_active),
        .lnk_dat   (lnk_dat),
        .word_hold (word_hold),
        .word_tgl  (word_tgl)
    );

    lpboot_tglsync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgl_in (word_tgl),
        .pulse  (word_pulse)
    );

    lpboot_ctrl #(
        .ADDR_W     (ADDR_W),
        .BOOT_WORDS (BOOT_WORDS),
        .BOOT_BASE  (BOOT_BASE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_ext   (strap_ext),
        .strap_link  (strap_link),
        .strap_sel   (strap_sel),
        .word_pulse  (word_pulse),
        .word_in     (word_hold),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .boot_active (boot_active),
        .boot_done   (boot_done)
    );
endmodule

// File: tb/lpboot_rx_tb.sv
module lpboot_rx_tb;
    localparam int ADDR_W = 17;
    localparam int NW = 256;
    localparam logic [ADDR_W-1:0] BASE = 17'h04000;

    logic clk = 0, rst_n = 0;
    logic strap_ext = 1, strap_link = 0, strap_sel = 0;
    logic lnk_clk = 1;
    logic [3:0] lnk_dat = 0;
    logic mem_we, boot_active, boot_done;
    logic [ADDR_W-1:0] mem_addr;
    logic [47:0] mem_wdata;

    int checks = 0, fails = 0, wr_cnt = 0;
    logic [47:0] exp_w [NW];
    bit mon_on = 0;

    always #5 clk = ~clk;

    lpboot_rx u_dut (
        .clk(clk), .rst_n(rst_n), .strap_ext(strap_ext), .strap_link(strap_link),
        .strap_sel(strap_sel), .lnk_clk(lnk_clk), .lnk_dat(lnk_dat),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .boot_active(boot_active), .boot_done(boot_done)
    );

    function automatic logic [ADDR_W-1:0] exp_addr(int k);
        return BASE + ADDR_W'(k);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_nib(logic [3:0] n, bit fast);
        int h;
        h = fast ? 5 : 5 + int'($urandom % 8);
        lnk_dat = n;
        #(h) lnk_clk = 0;
        #(h) lnk_clk = 1;
    endtask

    task automatic send_word(logic [47:0] w, bit fast);
        for (int i = 11; i >= 0; i--) send_nib(w[i*4 +: 4], fast);
    endtask

    task automatic do_reset(logic e, logic l, logic s);
        rst_n = 0;
        strap_ext = e; strap_link = l; strap_sel = s;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        repeat (3) @(posedge clk);
        #2;
    endtask

    // monitor: compare every write in order
    always @(negedge clk) begin
        if (mon_on && mem_we) begin
            if (wr_cnt < NW) begin
                chk(mem_wdata == exp_w[wr_cnt], "R2/R3 data", 64'(mem_wdata), 64'(exp_w[wr_cnt]));
                chk(mem_addr == exp_addr(wr_cnt), "R4 addr", 64'(mem_addr), 64'(exp_addr(wr_cnt)));
                chk(boot_done == (wr_cnt == NW - 1), "R5 done timing", 64'(boot_done), 64'(wr_cnt == NW - 1));
            end else begin
                chk(0, "R6 write after done", 64'(wr_cnt), 64'(NW));
            end
            wr_cnt++;
        end
    end

    initial begin
        #3_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NW; k++) exp_w[k] = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        exp_w[0] = 48'h123456789ABC;
        exp_w[NW-1] = 48'hFEDCBA987654;
        mon_on = 1;

        // R1: all non-matching strap combinations stay idle
        for (int c = 0; c < 8; c++) begin
            if (c == 3) continue;  // {ext,link,sel} = 0,1,1 is the matching one
            wr_cnt = 0;
            do_reset(c[2], c[1], c[0]);
            send_word(48'hAAAA55550000, 0);
            send_word(48'h0F0F0F0F0F0F, 0);
            repeat (8) @(posedge clk);
            #2;
            chk(wr_cnt == 0, "R1 no write when straps mismatch", 64'(wr_cnt), 0);
            chk(!boot_active && !boot_done, "R1/R9 idle flags", {boot_active, boot_done}, 0);
        end

        // R1/R9: matching straps
        wr_cnt = 0;
        do_reset(0, 1, 1);
        chk(boot_active == 1, "R9 active after good strap", 64'(boot_active), 1);
        chk(boot_done == 0 && mem_we == 0, "R1 reset state", {boot_done, mem_we}, 0);

        // R7: partial word then reset
        for (int i = 0; i < 5; i++) send_nib(4'hF, 0);
        repeat (8) @(posedge clk);
        #2;
        chk(wr_cnt == 0, "R7 partial produces no write", 64'(wr_cnt), 0);
        do_reset(0, 1, 1);

        // R2..R5, R8: full image, fast strobe for the first and last blocks
        for (int k = 0; k < NW; k++) begin
            send_word(exp_w[k], (k < 16) || (k >= NW - 16));
            if (k == NW - 2) begin
                repeat (8) @(posedge clk);
                #2;
                chk(boot_done == 0, "R5 not done before last word", 64'(boot_done), 0);
                chk(wr_cnt == NW - 1, "R8 no lost words", 64'(wr_cnt), 64'(NW - 1));
            end
        end
        repeat (8) @(posedge clk);
        #2;
        chk(wr_cnt == NW, "R5/R8 total writes", 64'(wr_cnt), 64'(NW));
        chk(boot_done == 1, "R5 done raised", 64'(boot_done), 1);
        chk(boot_active == 0, "R9 inactive after done", 64'(boot_active), 0);

        // R6: traffic after done is ignored
        send_word(48'h111122223333, 0);
        send_word(48'h444455556666, 1);
        repeat (10) @(posedge clk);
        #2;
        chk(wr_cnt == NW, "R6 no writes after done", 64'(wr_cnt), 64'(NW));
        chk(boot_done == 1, "R5 done held", 64'(boot_done), 1);

        // reset clears done
        do_reset(0, 1, 1);
        chk(boot_done == 0 && boot_active == 1, "R5/R9 reset clears done", {boot_done, boot_active}, 64'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule